// File: doc/BRIEF.md
# Vector Load Return Data Writer

This block takes the data returned for one vector memory instruction and turns it into register-file write strobes. The data comes back as one packed buffer of memory elements, each 1, 2, 4 or 8 bytes wide. The block reads the elements for each destination register. It widens every element to the register width, either 32 or 64 bits, using sign extension or zero extension as the memory type requires. It then presents one register per cycle with all lanes in parallel. Each lane has its own lane enable and byte enables, so lanes whose execution-mask bit is clear are never written.

A single-cycle `start` captures the whole request: operation kind, memory type, register width, execution mask, register count, base register, explicit index list and data buffer. Small register counts write consecutive registers from the base. Larger counts take each destination from the index list. Several kinds of request are rejected before any write is made: an illegal type pairing, too many registers, or more data than one instruction may carry. Stores and non-returning atomics complete with no writes at all. Every request ends with a single-cycle `done`.

Top module: `vload_return_writer`

## Requirements
- R1: While and after reset, with no request, `wr_en`, `done`, `err`, `wr_lane_en` and `wr_be` are all zero.
- R2: For an accepted request that writes N registers, the writes for register k = 0..N-1 appear on `wr_en` in the k+1-th cycle after the `start` cycle. `done` is high for exactly one cycle, directly after the last write, or in the first cycle after `start` when nothing is written.
- R3: Signed memory types (code 4 = 8-bit, 5 = 16-bit, 6 = 32-bit, 7 = 64-bit) are sign-extended to the register width.
- R4: Unsigned memory types (code 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) are zero-extended. Float codes 8 (32-bit) and 9 (64-bit) pass through unchanged when their size equals the register width. With `reg_wide` = 0 the upper 32 bits of each lane's data are zero.
- R5: The element for register k, lane i, is read little-endian from byte offset (k*LANES + i) * element size of `ret_data`, where byte b occupies bits [8b+7:8b].
- R6: During a write, `wr_lane_en` equals `exec_mask`. An enabled lane gets byte enables 8'h0F (32-bit register) or 8'hFF (64-bit register) in its `wr_be` slice. A disabled lane has zero byte enables and zero data.
- R7: When `reg_count` is at most LIST_THRESH (default 2), register k goes to `base_reg` + k, modulo 2^IDX_W. Above that threshold, register k goes to `idx_list[k*IDX_W +: IDX_W]`.
- R8: A writing operation produces no writes and raises `err` together with `done` in any of these cases: element size times `reg_count` exceeds MAX_BYTES (default 16); `reg_count` exceeds MAX_REGS; a 64-bit integer type is paired with a 32-bit register; a float type's size differs from the register width; the memory type code is above 9.
- R9: Only `op` = 0 (load) and `op` = 2 (returning atomic) write registers. `op` = 1 (store) and `op` = 3 (non-returning atomic) finish with `done`, no writes and no `err`, whatever the type.
- R10: A `start` raised while a request is still in progress is ignored. The running request's writes use the values captured at its own start, and no extra request follows.
- R11: A writing request with `reg_count` = 0 finishes with `done`, no writes and no `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| op | input | 2 | 0 load, 1 store, 2 returning atomic, 3 non-returning atomic |
| mem_type | input | 4 | Memory element type code |
| reg_wide | input | 1 | 1 = 64-bit registers, 0 = 32-bit registers |
| exec_mask | input | LANES | Per-lane execution mask |
| reg_count | input | $clog2(MAX_REGS+1) | Number of destination registers |
| base_reg | input | IDX_W | First destination for sequential numbering |
| idx_list | input | MAX_REGS*IDX_W | Explicit destination list, entry k at bits k*IDX_W |
| ret_data | input | MAX_BYTES*LANES*8 | Packed returned elements |
| wr_en | output | 1 | Register write valid this cycle |
| wr_idx | output | IDX_W | Destination register index |
| wr_lane_en | output | LANES | Lanes written this cycle |
| wr_be | output | LANES*8 | Byte enables, 8 per lane |
| wr_data | output | LANES*64 | Extended lane data, 64 bits per lane |
| done | output | 1 | Single-cycle completion pulse |
| err | output | 1 | Request rejected, high together with done |

## Verification
Every integer type code is run with both register widths, using random element values, so that sign and zero extension are told apart for elements whose top bit is set and for those where it is clear. Full, empty and alternating execution masks separate lane gating from the data path. Register counts at and above the threshold, including a base index that wraps, tell sequential numbering from list numbering. The rejected pairings, the oversize spans, the non-writing operations, a zero count and a second start mid-request each show that the write stream stays silent or unchanged while `done` and `err` take the expected values.

// File: rtl/vlrw_pkg.sv
package vlrw_pkg;

    typedef enum logic [1:0] {
        OP_LOAD       = 2'd0,
        OP_STORE      = 2'd1,
        OP_ATOM_RET   = 2'd2,
        OP_ATOM_NORET = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    // element descriptor decoded from the memory type code
    typedef struct packed {
        logic [1:0] lg;     // log2 of element bytes
        logic       sgn;    // sign-extend
        logic       flt;    // float, passes unchanged
        logic       legal;  // known code
    } elem_info_t;

    function automatic elem_info_t decode_mtype(input logic [3:0] mt);
        elem_info_t i;
        i = '0;
        if (mt <= 4'd7) begin
            i.lg    = mt[1:0];
            i.sgn   = mt[2];
            i.legal = 1'b1;
        end else if (mt == 4'd8) begin
            i.lg    = 2'd2;
            i.flt   = 1'b1;
            i.legal = 1'b1;
        end else if (mt == 4'd9) begin
            i.lg    = 2'd3;
            i.flt   = 1'b1;
            i.legal = 1'b1;
        end
        return i;
    endfunction

    function automatic logic pair_ok(input elem_info_t i, input logic wide);
        if (!i.legal)
            return 1'b0;
        else if (i.flt)
            return (i.lg == 2'd3) == wide;
        else
            return !((i.lg == 2'd3) && !wide);
    endfunction

    function automatic logic op_writes(input logic [1:0] op);
        return (op == OP_LOAD) || (op == OP_ATOM_RET);
    endfunction

    function automatic logic [63:0] extend_elem(input logic [63:0] raw,
                                                input logic [1:0]  lg,
                                                input logic        sgn,
                                                input logic        wide);
        logic [63:0] v;
        case (lg)
            2'd0:    v = sgn ? {{56{raw[7]}},  raw[7:0]}  : {56'd0, raw[7:0]};
            2'd1:    v = sgn ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
            2'd2:    v = sgn ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
            default: v = raw;
        endcase
        if (!wide)
            v[63:32] = '0;
        return v;
    endfunction

endpackage

// File: rtl/vlrw_ctrl.sv
module vlrw_ctrl
    import vlrw_pkg::*;
#(
    parameter int MAX_REGS  = 4,
    parameter int MAX_BYTES = 16,
    parameter int KW        = 2,
    parameter int CW        = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [3:0]    mem_type,
    input  logic          reg_wide,
    input  logic [CW-1:0] reg_count,
    output logic          accept,
    output logic [KW-1:0] k,
    output logic [1:0]    lg_q,
    output logic          sgn_q,
    output logic          wr_en,
    output logic          done,
    output logic          err
);

    state_e        state;
    elem_info_t    info;
    logic          writes;
    logic          too_big;
    logic          bad;
    logic          skip;
    logic          err_q;
    logic [KW-1:0] last_k;
    int            span;

    always_comb begin
        info    = decode_mtype(mem_type);
        writes  = op_writes(op);
        span    = (1 << info.lg) * int'(reg_count);
        too_big = (int'(reg_count) > MAX_REGS) || (span > MAX_BYTES);
        bad     = writes && (!pair_ok(info, reg_wide) || too_big);
        skip    = !writes || bad || (reg_count == '0);
        accept  = start && (state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            k      <= '0;
            last_k <= '0;
            err_q  <= 1'b0;
            lg_q   <= '0;
            sgn_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        err_q  <= bad;
                        lg_q   <= info.lg;
                        sgn_q  <= info.sgn;
                        k      <= '0;
                        last_k <= KW'(reg_count - CW'(1));
                        state  <= skip ? ST_FIN : ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (k == last_k)
                        state <= ST_FIN;
                    else
                        k <= k + KW'(1);
                end
                ST_FIN: begin
                    err_q <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wr_en = (state == ST_BUSY);
    assign done  = (state == ST_FIN);
    assign err   = (state == ST_FIN) && err_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                          // R2
    AST_K_STEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (k == $past(k) + KW'(1)));    // R2
    AST_WR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> $past(accept));                          // R2
    AST_NOWRITE_OP: assert property (@(posedge clk) disable iff (rst)
        (accept && !op_writes(op)) |=> (!wr_en && !err));         // R9

endmodule

// File: rtl/vlrw_dest.sv
module vlrw_dest #(
    parameter int MAX_REGS    = 4,
    parameter int LIST_THRESH = 2,
    parameter int IDX_W       = 8,
    parameter int KW          = 2,
    parameter int CW          = 3
) (
    input  logic [CW-1:0]             count,
    input  logic [IDX_W-1:0]          base,
    input  logic [MAX_REGS*IDX_W-1:0] list,
    input  logic [KW-1:0]             k,
    output logic [IDX_W-1:0]          idx,
    output logic                      list_mode
);

    generate
        if (LIST_THRESH >= MAX_REGS) begin : g_seq_only
            assign list_mode = 1'b0;
            assign idx       = base + IDX_W'(k);
        end else begin : g_seq_or_list
            assign list_mode = int'(count) > LIST_THRESH;
            assign idx       = list_mode ? list[int'(k)*IDX_W +: IDX_W]
                                         : base + IDX_W'(k);
        end
    endgenerate

endmodule

// File: rtl/vlrw_lane.sv
module vlrw_lane
    import vlrw_pkg::*;
#(
    parameter int LANE      = 0,
    parameter int LANES     = 4,
    parameter int BUF_BYTES = 64,
    parameter int KW        = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BUF_BYTES*8-1:0] buf_data,
    input  logic [KW-1:0]          k,
    input  logic [1:0]             lg,
    input  logic                   sgn,
    input  logic                   wide,
    input  logic                   lane_on,
    output logic [63:0]            data,
    output logic [7:0]             be
);

    logic [63:0] raw;
    logic [63:0] ext;

    // gather 8 bytes starting at this lane's element offset
    always_comb begin
        int off;
        off = (int'(k) * LANES + LANE) << lg;
        for (int b = 0; b < 8; b++) begin
            if (off + b < BUF_BYTES)
                raw[b*8 +: 8] = buf_data[(off + b)*8 +: 8];
            else
                raw[b*8 +: 8] = 8'h00;
        end
        ext = extend_elem(raw, lg, sgn, wide);
    end

    assign data = lane_on ? ext : '0;
    assign be   = lane_on ? (wide ? 8'hFF : 8'h0F) : 8'h00;

    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
        (lane_on && sgn && lg == 2'd0) |-> (data[31:8] == {24{data[7]}}));  // R3
    AST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (lane_on && !sgn && lg == 2'd1) |-> (data[31:16] == '0));           // R4
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (lane_on && !wide) |-> (data[63:32] == '0));                        // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lane_on |-> (be == '0 && data == '0));                             // R6

endmodule

// File: rtl/vload_return_writer.sv
module vload_return_writer
    import vlrw_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int MAX_REGS    = 4,
    parameter int LIST_THRESH = 2,
    parameter int MAX_BYTES   = 16,
    parameter int IDX_W       = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic [1:0]                       op,
    input  logic [3:0]                       mem_type,
    input  logic                             reg_wide,
    input  logic [LANES-1:0]                 exec_mask,
    input  logic [$clog2(MAX_REGS+1)-1:0]    reg_count,
    input  logic [IDX_W-1:0]                 base_reg,
    input  logic [MAX_REGS*IDX_W-1:0]        idx_list,
    input  logic [MAX_BYTES*LANES*8-1:0]     ret_data,
    output logic                             wr_en,
    output logic [IDX_W-1:0]                 wr_idx,
    output logic [LANES-1:0]                 wr_lane_en,
    output logic [LANES*8-1:0]               wr_be,
    output logic [LANES*64-1:0]              wr_data,
    output logic                             done,
    output logic                             err
);

    localparam int BUF_BYTES = MAX_BYTES * LANES;
    localparam int CW        = $clog2(MAX_REGS + 1);
    localparam int KW        = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

    logic                      accept;
    logic [KW-1:0]             k;
    logic [1:0]                lg_q;
    logic                      sgn_q;
    logic                      list_mode;

    logic [LANES-1:0]          mask_q;
    logic [CW-1:0]             cnt_q;
    logic [IDX_W-1:0]          base_q;
    logic [MAX_REGS*IDX_W-1:0] list_q;
    logic [BUF_BYTES*8-1:0]    buf_q;
    logic                      wide_q;

    vlrw_ctrl #(
        .MAX_REGS (MAX_REGS),
        .MAX_BYTES(MAX_BYTES),
        .KW       (KW),
        .CW       (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op       (op),
        .mem_type (mem_type),
        .reg_wide (reg_wide),
        .reg_count(reg_count),
        .accept   (accept),
        .k        (k),
        .lg_q     (lg_q),
        .sgn_q    (sgn_q),
        .wr_en    (wr_en),
        .done     (done),
        .err      (err)
    );

    // capture the request so the source may move on after start
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            cnt_q  <= '0;
            base_q <= '0;
            list_q <= '0;
            buf_q  <= '0;
            wide_q <= 1'b0;
        end else if (accept) begin
            mask_q <= exec_mask;
            cnt_q  <= reg_count;
            base_q <= base_reg;
            list_q <= idx_list;
            buf_q  <= ret_data;
            wide_q <= reg_wide;
        end
    end

    vlrw_dest #(
        .MAX_REGS   (MAX_REGS),
        .LIST_THRESH(LIST_THRESH),
        .IDX_W      (IDX_W),
        .KW         (KW),
        .CW         (CW)
    ) u_dest (
        .count    (cnt_q),
        .base     (base_q),
        .list     (list_q),
        .k        (k),
        .idx      (wr_idx),
        .list_mode(list_mode)
    );

    assign wr_lane_en = wr_en ? mask_q : '0;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            vlrw_lane #(
                .LANE     (l),
                .LANES    (LANES),
                .BUF_BYTES(BUF_BYTES),
                .KW       (KW)
            ) u_lane (
                .clk     (clk),
                .rst     (rst),
                .buf_data(buf_q),
                .k       (k),
                .lg      (lg_q),
                .sgn     (sgn_q),
                .wide    (wide_q),
                .lane_on (wr_en && mask_q[l]),
                .data    (wr_data[l*64 +: 64]),
                .be      (wr_be[l*8 +: 8])
            );
        end
    endgenerate

    AST_LANE_SUBSET: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_lane_en & ~mask_q) == '0));                         // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (wr_lane_en == '0 && wr_be == '0));                     // R1
    AST_SEQ_DEST: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && !list_mode)
            |-> (wr_idx == $past(wr_idx) + IDX_W'(1)));                    // R7
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        err |-> !wr_en);                                                   // R8

endmodule

// File: tb/tb_vload_return_writer.sv
`timescale 1ns/1ps
module tb_vload_return_writer;

    localparam int LANES     = 4;
    localparam int MAX_REGS  = 4;
    localparam int THRESH    = 2;
    localparam int MAX_BYTES = 16;
    localparam int IDX_W     = 8;
    localparam int BUF_BYTES = MAX_BYTES * LANES;
    localparam int CW        = $clog2(MAX_REGS + 1);

    logic                        clk = 1'b0;
    logic                        rst;
    logic                        start;
    logic [1:0]                  op;
    logic [3:0]                  mem_type;
    logic                        reg_wide;
    logic [LANES-1:0]            exec_mask;
    logic [CW-1:0]               reg_count;
    logic [IDX_W-1:0]            base_reg;
    logic [MAX_REGS*IDX_W-1:0]   idx_list;
    logic [BUF_BYTES*8-1:0]      ret_data;
    logic                        wr_en;
    logic [IDX_W-1:0]            wr_idx;
    logic [LANES-1:0]            wr_lane_en;
    logic [LANES*8-1:0]          wr_be;
    logic [LANES*64-1:0]         wr_data;
    logic                        done;
    logic                        err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] elem [0:BUF_BYTES-1];

    always #4 clk = ~clk;   // 8 ns period

    vload_return_writer #(
        .LANES(LANES), .MAX_REGS(MAX_REGS), .LIST_THRESH(THRESH),
        .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .mem_type(mem_type),
        .reg_wide(reg_wide), .exec_mask(exec_mask), .reg_count(reg_count),
        .base_reg(base_reg), .idx_list(idx_list), .ret_data(ret_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_lane_en(wr_lane_en), .wr_be(wr_be),
        .wr_data(wr_data), .done(done), .err(err)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic int esize(input int mt);
        case (mt)
            0, 4:    return 1;
            1, 5:    return 2;
            2, 6, 8: return 4;
            3, 7, 9: return 8;
            default: return 1;
        endcase
    endfunction

    // reference widening, written per type code
    function automatic logic [63:0] ref_ext(input logic [63:0] e, input int mt, input bit wide);
        logic [63:0] v;
        case (mt)
            0: v = {56'd0, e[7:0]};
            1: v = {48'd0, e[15:0]};
            2: v = {32'd0, e[31:0]};
            4: v = e[7]  ? {56'hFF_FFFF_FFFF_FFFF, e[7:0]}  : {56'd0, e[7:0]};
            5: v = e[15] ? {48'hFFFF_FFFF_FFFF, e[15:0]}    : {48'd0, e[15:0]};
            6: v = e[31] ? {32'hFFFF_FFFF, e[31:0]}         : {32'd0, e[31:0]};
            8: v = {32'd0, e[31:0]};
            default: v = e;
        endcase
        if (!wide) v[63:32] = 32'd0;
        return v;
    endfunction

    // one request: fill buffer, start, follow the write stream cycle by cycle
    task automatic run(input int o, input int mt, input bit wide, input int cnt,
                       input logic [LANES-1:0] mask, input logic [7:0] base,
                       input logic [31:0] list, input bit exp_err, input int exp_n,
                       input bit poke, input string tag);
        int es;
        logic [BUF_BYTES*8-1:0] bufv;
        es = esize(mt);
        bufv = '0;
        for (int e = 0; e < BUF_BYTES / es; e++) begin
            elem[e] = {$urandom, $urandom};
            for (int b = 0; b < es; b++)
                bufv[(e*es + b)*8 +: 8] = elem[e][b*8 +: 8];
        end
        @(negedge clk);
        op = 2'(o); mem_type = 4'(mt); reg_wide = wide; exec_mask = mask;
        reg_count = CW'(cnt); base_reg = base; idx_list = list; ret_data = bufv;
        start = 1'b1;
        for (int c = 1; c <= exp_n + 1; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (c <= exp_n) begin
                int kk;
                logic [7:0] eidx;
                kk = c - 1;
                eidx = (cnt > THRESH) ? list[kk*8 +: 8] : base + 8'(kk);
                chk({tag, " R2 write strobe"}, 64'(wr_en), 64'd1);
                chk({tag, " R7 dest index"}, 64'(wr_idx), 64'(eidx));
                chk({tag, " R6 lane enables"}, 64'(wr_lane_en), 64'(mask));
                for (int l = 0; l < LANES; l++) begin
                    chk({tag, " R6 byte enables"}, 64'(wr_be[l*8 +: 8]),
                        mask[l] ? (wide ? 64'hFF : 64'h0F) : 64'h00);
                    if (mask[l])
                        chk({tag, " R5 lane data"}, wr_data[l*64 +: 64],
                            ref_ext(elem[kk*LANES + l], mt, wide));
                end
            end else begin
                chk({tag, " R2 done pulse"}, 64'(done), 64'd1);
                chk({tag, " R8 err flag"}, 64'(err), 64'(exp_err));
                chk({tag, " R2 no write at done"}, 64'(wr_en), 64'd0);
            end
            if (poke && c == 1) begin
                start = 1'b1; base_reg = base + 8'd77; idx_list = ~list; mem_type = 4'd4;
            end
        end
        @(negedge clk);
        chk({tag, " R2 done single cycle"}, 64'(done), 64'd0);
        chk({tag, " R2 idle after done"}, 64'(wr_en), 64'd0);
        if (poke) begin
            repeat (2) @(negedge clk);
            chk({tag, " R10 no follow-on request"}, 64'({wr_en, done}), 64'd0);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; op = '0; mem_type = '0; reg_wide = 1'b0;
        exec_mask = '0; reg_count = '0; base_reg = '0; idx_list = '0; ret_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", 64'({wr_en, done, err, wr_lane_en}), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 outputs after reset", 64'({wr_en, done, err, wr_lane_en}), 64'd0);
        chk("R1 byte enables after reset", 64'(wr_be), 64'd0);
    endtask

    task automatic t_unsigned;
        for (int w = 0; w < 2; w++)
            for (int mt = 0; mt < 3; mt++) begin
                int cnt;
                cnt = (MAX_BYTES / esize(mt) > MAX_REGS) ? MAX_REGS : MAX_BYTES / esize(mt);
                run(0, mt, w[0], cnt, 4'(~(1 << mt)), 8'd10, 32'd0, 1'b0,
                    cnt, 1'b0, "R4 unsigned");
            end
        run(0, 3, 1'b1, 2, 4'hF, 8'd20, 32'd0, 1'b0, 2, 1'b0, "R4 unsigned 64");
    endtask

    task automatic t_signed;
        for (int w = 0; w < 2; w++)
            for (int mt = 4; mt < 7; mt++) begin
                int cnt;
                cnt = (MAX_BYTES / esize(mt) > MAX_REGS) ? MAX_REGS : MAX_BYTES / esize(mt);
                run(2, mt, w[0], cnt, 4'hF, 8'd30, 32'h0C0B0A09, 1'b0,
                    cnt, 1'b0, "R3 signed");
            end
        run(0, 7, 1'b1, 2, 4'hF, 8'd40, 32'd0, 1'b0, 2, 1'b0, "R3 signed 64");
    endtask

    task automatic t_float;
        run(0, 8, 1'b0, 4, 4'hF, 8'd50, 32'h04030201, 1'b0, 4, 1'b0, "R4 float32");
        run(0, 9, 1'b1, 2, 4'hF, 8'd60, 32'd0, 1'b0, 2, 1'b0, "R4 float64");
    endtask

    task automatic t_masks;
        run(0, 2, 1'b1, 2, 4'h0, 8'd70, 32'd0, 1'b0, 2, 1'b0, "R6 mask none");
        run(0, 2, 1'b1, 2, 4'hF, 8'd70, 32'd0, 1'b0, 2, 1'b0, "R6 mask all");
        run(0, 5, 1'b0, 2, 4'b0101, 8'd70, 32'd0, 1'b0, 2, 1'b0, "R6 mask alternate");
    endtask

    task automatic t_dest;
        run(0, 1, 1'b0, 2, 4'hF, 8'd255, 32'hAABBCCDD, 1'b0, 2, 1'b0, "R7 wrap sequential");
        run(0, 0, 1'b0, 3, 4'hF, 8'd5, 32'h11223344, 1'b0, 3, 1'b0, "R7 list three");
        run(2, 2, 1'b0, 4, 4'hE, 8'd5, 32'h80407F01, 1'b0, 4, 1'b0, "R7 list four");
    endtask

    task automatic t_errors;
        run(0, 3, 1'b0, 1, 4'hF, 8'd0, 32'd0, 1'b1, 0, 1'b0, "R8 u64 narrow");
        run(0, 9, 1'b0, 1, 4'hF, 8'd0, 32'd0, 1'b1, 0, 1'b0, "R8 f64 narrow");
        run(0, 8, 1'b1, 1, 4'hF, 8'd0, 32'd0, 1'b1, 0, 1'b0, "R8 f32 wide");
        run(2, 12, 1'b1, 1, 4'hF, 8'd0, 32'd0, 1'b1, 0, 1'b0, "R8 bad code");
        run(0, 3, 1'b1, 3, 4'hF, 8'd0, 32'd0, 1'b1, 0, 1'b0, "R8 span too big");
        run(0, 0, 1'b0, 5, 4'hF, 8'd0, 32'd0, 1'b1, 0, 1'b0, "R8 count too big");
    endtask

    task automatic t_nowrite;
        run(1, 2, 1'b0, 2, 4'hF, 8'd0, 32'd0, 1'b0, 0, 1'b0, "R9 store");
        run(3, 3, 1'b0, 2, 4'hF, 8'd0, 32'd0, 1'b0, 0, 1'b0, "R9 atomic no return");
        run(0, 0, 1'b0, 0, 4'hF, 8'd9, 32'd0, 1'b0, 0, 1'b0, "R11 zero count");
    endtask

    task automatic t_busy;
        run(0, 1, 1'b1, 4, 4'hB, 8'd100, 32'h13121110, 1'b0, 4, 1'b1, "R10 start while busy");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset;
        t_unsigned;
        t_signed;
        t_float;
        t_masks;
        t_dest;
        t_errors;
        t_nowrite;
        t_busy;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule